// File: doc/BRIEF.md
# LCD Power-Up Initialization Sequencer

The block brings a small monochrome graphic panel from system reset to a configured, switched-on state. It first holds the panel's hardware reset line low for a power-stabilization interval. It then releases that line and waits a short recovery time. After that it walks a built-in list of configuration bytes and hands each one to an external byte transmitter.

The transmitter interface carries a byte, a command/data flag, a valid strobe and a busy return. A byte is handed over on a clock edge where valid is high and busy is low. Every byte in the list is a command, and so is the argument byte of each two-byte command, so the flag stays low throughout. The list sets the bias and the scan directions, selects the booster, sets the regulation ratio and the contrast, enables all power blocks, and finally turns the display on. When the transmitter has finished the last byte, `ready_o` rises and stays high until the next system reset.

Top module: `lcd_init_seq`

## Requirements
- R1: After `rst_ni` is released, `panel_rst_no` stays low for exactly `HOLD_CYCLES` rising clock edges, then goes high and remains high until the next reset.
- R2: The first `tx_valid_o` appears exactly `RECOVER_CYCLES` rising edges after `panel_rst_no` goes high. `tx_valid_o` is never high while `panel_rst_no` is low.
- R3: The bytes are handed over in this order: 0xA2, 0xA0, 0xC8, 0xF8, 0x01, 0x27, 0x81, contrast byte, 0x2F, 0xAF. Display-on (0xAF) is the last byte.
- R4: `tx_dc_o` is low (command) for every byte handed over, including the second byte of the booster and contrast pairs.
- R5: While `tx_valid_o` is high and `tx_busy_i` is high, the sequencer holds `tx_valid_o` high and keeps `tx_byte_o` unchanged on the next cycle. Nothing is handed over while busy stays high.
- R6: Each list entry is handed over exactly once. After a handover, `tx_valid_o` stays low until `tx_busy_i` has returned low.
- R7: `ready_o` is low until `tx_busy_i` falls after the final byte. It then stays high and `tx_valid_o` stays low until reset.
- R8: The contrast byte is the parameter `CONTRAST` reduced to its low 6 bits (range 0 to 63), with bits 7:6 zero. The default is 44 (0x2C).
- R9: Asserting `rst_ni` at any point immediately forces `panel_rst_no` low and `tx_valid_o` and `ready_o` low. The next release restarts the whole sequence from the hold interval.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | System clock |
| rst_ni | input | 1 | Asynchronous active-low system reset |
| panel_rst_no | output | 1 | Panel hardware reset, active low |
| tx_byte_o | output | 8 | Byte offered to the transmitter |
| tx_dc_o | output | 1 | Command/data flag, 0 = command |
| tx_valid_o | output | 1 | Byte offer strobe |
| tx_busy_i | input | 1 | Transmitter busy; a byte is taken when valid is high and busy is low |
| ready_o | output | 1 | Panel configured and switched on |

## Verification
The bench builds the block with `HOLD_CYCLES` = 20 and `RECOVER_CYCLES` = 7. With these values, the exact reset-hold length and recovery gap can be counted cycle by cycle, and a complete sequence takes only a few dozen cycles. That short run lets the bench sweep every transmitter busy length from 1 to 6 cycles. It also covers a transmitter that stays busy long after the first offer, and a reset that lands in the middle of the command list.

// File: rtl/lcd_init_pkg.sv
package lcd_init_pkg;

  localparam int SEQ_LEN = 10;

  typedef enum logic [2:0] {
    ST_HOLD,
    ST_RECOVER,
    ST_ISSUE,
    ST_GAP,
    ST_WAIT,
    ST_DONE
  } seq_state_e;

  // configuration list; entry 7 carries the contrast argument
  function automatic logic [7:0] seq_byte(input int unsigned idx, input logic [5:0] ev);
    logic [7:0] b;
    case (idx)
      0:       b = 8'hA2;         // bias 1/9
      1:       b = 8'hA0;         // segment scan normal
      2:       b = 8'hC8;         // common scan reversed
      3:       b = 8'hF8;         // booster select
      4:       b = 8'h01;         // booster x5
      5:       b = 8'h27;         // regulation ratio
      6:       b = 8'h81;         // contrast set
      7:       b = {2'b00, ev};   // contrast value
      8:       b = 8'h2F;         // all power blocks on
      default: b = 8'hAF;         // display on, always last
    endcase
    return b;
  endfunction

endpackage

// File: rtl/lcd_init_timer.sv
module lcd_init_timer #(
  parameter int CNT_W = 8
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             run_i,
  input  logic [CNT_W-1:0] limit_i,
  output logic             done_o
);

  logic [CNT_W-1:0] cnt_q;

  assign done_o = run_i && (cnt_q == limit_i - 1'b1);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)                cnt_q <= '0;
    else if (!run_i || done_o)  cnt_q <= '0;
    else                        cnt_q <= cnt_q + 1'b1;
  end

  // R1
  timer_bound_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    run_i |-> (cnt_q < limit_i));

endmodule

// File: rtl/lcd_init_rom.sv
module lcd_init_rom
  import lcd_init_pkg::*;
#(
  parameter int CONTRAST = 44,
  parameter int IDX_W    = 4
) (
  input  logic [IDX_W-1:0] idx_i,
  output logic [7:0]       byte_o,
  output logic             last_o
);

  localparam logic [5:0] EV = 6'(CONTRAST);

  assign byte_o = seq_byte(int'(idx_i), EV);
  assign last_o = (int'(idx_i) == SEQ_LEN - 1);

endmodule

// File: rtl/lcd_init_seq.sv
module lcd_init_seq
  import lcd_init_pkg::*;
#(
  parameter int HOLD_CYCLES    = 2_500_000,
  parameter int RECOVER_CYCLES = 2_500,
  parameter int CONTRAST       = 44
) (
  input  logic       clk_i,
  input  logic       rst_ni,
  output logic       panel_rst_no,
  output logic [7:0] tx_byte_o,
  output logic       tx_dc_o,
  output logic       tx_valid_o,
  input  logic       tx_busy_i,
  output logic       ready_o
);

  localparam int MAX_WAIT = (HOLD_CYCLES > RECOVER_CYCLES) ? HOLD_CYCLES : RECOVER_CYCLES;
  localparam int CNT_W    = $clog2(MAX_WAIT + 1);
  localparam int IDX_W    = $clog2(SEQ_LEN);

  seq_state_e       state_q, state_d;
  logic [IDX_W-1:0] idx_q;
  logic             tmr_run, tmr_done, last;
  logic [CNT_W-1:0] tmr_limit;

  assign tmr_run   = (state_q == ST_HOLD) || (state_q == ST_RECOVER);
  assign tmr_limit = (state_q == ST_HOLD) ? CNT_W'(HOLD_CYCLES) : CNT_W'(RECOVER_CYCLES);

  lcd_init_timer #(.CNT_W(CNT_W)) u_timer (
    .clk_i   (clk_i),
    .rst_ni  (rst_ni),
    .run_i   (tmr_run),
    .limit_i (tmr_limit),
    .done_o  (tmr_done)
  );

  lcd_init_rom #(.CONTRAST(CONTRAST), .IDX_W(IDX_W)) u_rom (
    .idx_i  (idx_q),
    .byte_o (tx_byte_o),
    .last_o (last)
  );

  always_comb begin
    state_d = state_q;
    case (state_q)
      ST_HOLD:    if (tmr_done) state_d = ST_RECOVER;
      ST_RECOVER: if (tmr_done) state_d = ST_ISSUE;
      ST_ISSUE:   if (!tx_busy_i) state_d = ST_GAP;
      ST_GAP:     state_d = ST_WAIT;  // let busy rise
      ST_WAIT:    if (!tx_busy_i) state_d = last ? ST_DONE : ST_ISSUE;
      ST_DONE:    state_d = ST_DONE;
      default:    state_d = ST_HOLD;
    endcase
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      state_q <= ST_HOLD;
      idx_q   <= '0;
    end else begin
      state_q <= state_d;
      if (state_q == ST_WAIT && !tx_busy_i && !last) idx_q <= idx_q + 1'b1;
    end
  end

  assign panel_rst_no = (state_q != ST_HOLD);
  assign tx_valid_o   = (state_q == ST_ISSUE);
  assign tx_dc_o      = 1'b0;
  assign ready_o      = (state_q == ST_DONE);

  // R1
  panel_rst_stays_high_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    panel_rst_no |=> panel_rst_no);

  // R2
  no_offer_in_reset_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !panel_rst_no |-> !tx_valid_o);

  // R5
  offer_held_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (tx_valid_o && tx_busy_i) |=> (tx_valid_o && $stable(tx_byte_o)));

  // R6
  single_handover_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (tx_valid_o && !tx_busy_i) |=> !tx_valid_o);

  // R7
  ready_sticky_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ready_o |=> ready_o);

  // R7
  quiet_when_ready_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ready_o |-> !tx_valid_o);

endmodule

// File: tb/tb_lcd_init_seq.sv
`timescale 1ns/1ps
module tb_lcd_init_seq;

  localparam int HOLD = 20;
  localparam int REC  = 7;
  localparam int N    = 10;

  logic clk = 1'b0;
  logic rst_ni = 1'b0;
  logic panel_rst_no, tx_dc_o, tx_valid_o, ready_o;
  logic [7:0] tx_byte_o;
  logic tx_busy_i = 1'b0;

  int errors = 0;
  int checks = 0;
  int blen = 1;
  bit model_en = 1'b1;
  int nrec = 0;
  logic [7:0] rec_byte [0:31];
  logic       rec_dc   [0:31];

  always #2 clk = ~clk;

  lcd_init_seq #(.HOLD_CYCLES(HOLD), .RECOVER_CYCLES(REC), .CONTRAST(44)) dut (
    .clk_i(clk), .rst_ni(rst_ni), .panel_rst_no(panel_rst_no),
    .tx_byte_o(tx_byte_o), .tx_dc_o(tx_dc_o), .tx_valid_o(tx_valid_o),
    .tx_busy_i(tx_busy_i), .ready_o(ready_o)
  );

  function automatic logic [7:0] exp_byte(int i);
    case (i)
      0: return 8'hA2; 1: return 8'hA0; 2: return 8'hC8; 3: return 8'hF8;
      4: return 8'h01; 5: return 8'h27; 6: return 8'h81; 7: return 8'h2C;
      8: return 8'h2F; default: return 8'hAF;
    endcase
  endfunction

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  // transmitter model: takes byte at the edge after a negedge offer, busy for blen edges
  initial begin
    forever begin
      @(negedge clk);
      if (model_en && rst_ni && tx_valid_o && !tx_busy_i) begin
        if (nrec < 32) begin
          rec_byte[nrec] = tx_byte_o;
          rec_dc[nrec]   = tx_dc_o;
        end
        nrec++;
        @(posedge clk); #1 tx_busy_i = 1'b1;
        repeat (blen) @(posedge clk);
        #1 tx_busy_i = 1'b0;
      end
    end
  end

  // full sequence from reset release, checks R1..R7
  task automatic run_seq(input int L);
    int low_cnt, first_high, first_valid, ready_at;
    logic [7:0] prev_byte;
    bit prev_hold;
    blen = L;
    @(negedge clk);
    rst_ni = 1'b0; nrec = 0;
    repeat (3) @(negedge clk);
    // R9 / reset state
    chk(!panel_rst_no && !tx_valid_o && !ready_o, "R9 reset state", int'(panel_rst_no), 0);
    rst_ni = 1'b1;
    low_cnt = 0; first_high = -1; first_valid = -1; ready_at = -1; prev_hold = 0; prev_byte = '0;
    for (int i = 0; i < 600; i++) begin
      if (!panel_rst_no) begin
        low_cnt++;
        if (first_high >= 0) chk(0, "R1 panel reset fell again", i, first_high);
        if (tx_valid_o) chk(0, "R2 valid during panel reset", i, -1);
      end else if (first_high < 0) first_high = i;
      if (tx_valid_o && first_valid < 0) first_valid = i;
      if (prev_hold) chk(tx_valid_o && tx_byte_o == prev_byte, "R5 offer dropped while busy", int'(tx_byte_o), int'(prev_byte));
      prev_hold = tx_valid_o && tx_busy_i;
      prev_byte = tx_byte_o;
      if (tx_valid_o && tx_busy_i && model_en) chk(0, "R6 offer while transmitter busy", i, -1);
      if (ready_o && ready_at < 0) begin
        ready_at = i;
        chk(nrec == N && !tx_busy_i, "R7 ready before final byte done", nrec, N);
      end
      if (ready_at >= 0 && i > ready_at + 20) break;
      if (ready_at >= 0) begin
        if (!ready_o) chk(0, "R7 ready dropped", 0, 1);
        if (tx_valid_o) chk(0, "R7 valid after ready", 1, 0);
      end
      @(negedge clk);
    end
    chk(low_cnt == HOLD, "R1 hold length", low_cnt, HOLD);
    chk(first_valid - first_high == REC, "R2 recovery gap", first_valid - first_high, REC);
    chk(ready_at >= 0, "R7 ready reached", ready_at, 1);
    chk(nrec == N, "R6 bytes handed over", nrec, N);
    for (int k = 0; k < N; k++) begin
      chk(rec_byte[k] == exp_byte(k), (k == 7) ? "R8 contrast byte" : "R3 byte order",
          int'(rec_byte[k]), int'(exp_byte(k)));
      chk(rec_dc[k] == 1'b0, "R4 command flag", int'(rec_dc[k]), 0);
    end
  endtask

  initial begin
    #(200000 * 4);
    errors++; checks++;
    $display("FAIL watchdog expired actual=0 expected=1");
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    // sweep transmitter busy lengths
    for (int L = 1; L <= 6; L++) run_seq(L);

    // stalled transmitter: offer must hold, nothing taken
    @(negedge clk);
    rst_ni = 1'b0; nrec = 0; model_en = 1'b0; tx_busy_i = 1'b1;
    repeat (2) @(negedge clk);
    rst_ni = 1'b1;
    repeat (HOLD + REC + 15) @(negedge clk);
    chk(tx_valid_o && tx_byte_o == 8'hA2, "R5 stalled offer held", int'(tx_byte_o), 8'hA2);
    chk(!ready_o, "R5 no progress while busy", int'(ready_o), 0);
    tx_busy_i = 1'b0; model_en = 1'b1; blen = 2;
    repeat (100) @(negedge clk);
    chk(ready_o && nrec == N, "R6 completes after stall", nrec, N);
    chk(rec_byte[0] == 8'hA2, "R6 first byte once", int'(rec_byte[0]), 8'hA2);

    // reset in the middle of the list
    @(negedge clk);
    rst_ni = 1'b0; nrec = 0;
    @(negedge clk);
    rst_ni = 1'b1;
    while (nrec < 5) @(negedge clk);
    #1 rst_ni = 1'b0;
    #1;
    chk(!panel_rst_no && !tx_valid_o && !ready_o, "R9 async reset mid-sequence", int'(panel_rst_no), 0);
    wait (!tx_busy_i);
    run_seq(3);

    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

endmodule